// File: doc/BRIEF.md
# Interleaved NAND Page-Program Scheduler

This block takes a byte stream from a capture source and writes it, page by page, into a bank of raw NAND flash devices. All devices in the bank share the 8-bit data lines, the chip-enable line and the command-latch and address-latch lines. Each device has its own write strobe and its own read strobe. A device is selected by pulsing only its write strobe. The scheduler hands page programs to the devices in round-robin order. Loading a page over the bus is quick, but committing it inside a device is slow, so each device commits while the next device is being loaded.

For each page the scheduler drives the program command, a fixed address, one page of data and then the confirm command. Before it touches a device it waits until that device reports ready. There is no remapping, so the device and page address of every page are fixed. After the last device in the rotation, the page address goes up by one and the rotation starts again at device 0. Block erase is not part of the streaming path.

The controller FSM has ten states:
- ST_WAIT holds until the current device is ready, then goes to ST_CMD_SU.
- ST_CMD_SU is a command-latch setup that lasts SETUP cycles, then goes to ST_CMD.
- ST_CMD issues the program command. When that pulse ends it goes to ST_ADR_SU.
- ST_ADR_SU is an address-latch setup, then goes to ST_ADR.
- ST_ADR issues the five address pulses. After the last one it goes to ST_DAT_SU.
- ST_DAT_SU is the setup with both latch lines low, then goes to ST_DAT.
- ST_DAT issues one pulse for each accepted byte. After the pulse for the last byte of the page it goes to ST_FIN_SU.
- ST_FIN_SU is a command-latch setup, then goes to ST_FIN.
- ST_FIN issues the confirm command, then goes to ST_DONE.
- ST_DONE lasts one cycle. It reports the completion, moves the rotation on and returns to ST_WAIT.

Top module: `nand_page_sched`

## Requirements
- R1: While reset is held, in_ready, done_pulse and the bank's nand_cle and nand_ale lines are 0, and nand_ce_n and every write and read strobe are 1.
- R2: Each page is sent as one program command byte 0x80 latched with nand_cle high. Then come five address bytes latched with nand_ale high: two column bytes of 0x00, then the page address low byte, middle byte and high byte. Then come PAGE_BYTES data bytes with both latch lines low. Last comes one confirm byte 0x10 latched with nand_cle high. A byte is latched on the rising edge of the device's write strobe.
- R3: In any cycle at most one write strobe is low. Every read strobe stays high. Pages go to devices in the order 0, 1, ..., NUM_CHIPS-1, 0, and so on.
- R4: The page address starts at 0 and goes up by one each time device NUM_CHIPS-1 completes a page.
- R5: While the next device in the rotation reports busy (its chip_rdy bit is 0), in_ready stays 0 and no write strobe is pulsed.
- R6: Every write-strobe pulse is low for exactly WE_LO cycles. It is followed by at least WE_HI cycles with all write strobes high before the next pulse. nand_io does not change while a strobe is low.
- R7: When nand_cle or nand_ale changes, all write strobes are high. At least SETUP cycles pass between the change and the next falling strobe.
- R8: nand_cle and nand_ale are never high together. nand_ce_n is low whenever a write strobe is low.
- R9: After each confirm command, done_pulse is high for exactly one cycle. In that cycle done_chip and done_page give the device index and page address of the page just completed.
- R10: Data bytes are accepted on the cycles where in_valid and in_ready are both high. The byte accepted in that cycle drives a strobe pulse that starts in the next cycle. Idle gaps in in_valid do not lose or reorder bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Scheduler accepts a byte this cycle |
| chip_rdy | input | NUM_CHIPS | Per-device ready (1) / busy (0) |
| nand_io | output | 8 | Shared data lines |
| nand_ce_n | output | 1 | Shared chip enable, active low |
| nand_cle | output | 1 | Shared command-latch enable |
| nand_ale | output | 1 | Shared address-latch enable |
| nand_we_n | output | NUM_CHIPS | Per-device write strobe, active low |
| nand_re_n | output | NUM_CHIPS | Per-device read strobe, held high |
| done_pulse | output | 1 | One-cycle page-complete flag |
| done_chip | output | $clog2(NUM_CHIPS) | Device index of the completed page |
| done_page | output | 8*ROW_BYTES | Page address of the completed page |

## Verification
A wrong state or counter shows up on the bus within one page sequence. A skipped or repeated setup state shows as a latch line that moves next to a strobe edge. An off-by-one address or byte counter shows as a shifted latch sequence in the device log by the next confirm command. A rotor fault shows on the very next done_pulse as an unexpected done_chip or done_page. A device-ready check that leaks shows as a strobe pulse to a busy device, or as in_ready rising while the wait is still in progress. The bench models every device and checks each of these cycle by cycle.

// File: rtl/nps_pkg.sv
package nps_pkg;
    localparam int BUS_W = 8;
    localparam int COL_BYTES = 2;
    localparam logic [BUS_W-1:0] OP_PROGRAM = 8'h80;
    localparam logic [BUS_W-1:0] OP_CONFIRM = 8'h10;

    typedef enum logic [3:0] {
        ST_WAIT,
        ST_CMD_SU,
        ST_CMD,
        ST_ADR_SU,
        ST_ADR,
        ST_DAT_SU,
        ST_DAT,
        ST_FIN_SU,
        ST_FIN,
        ST_DONE
    } sched_state_e;
endpackage

// File: rtl/nps_strobe.sv
module nps_strobe #(
    parameter int WE_LO = 2,
    parameter int WE_HI = 2
)(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic low,
    output logic fin
);
    localparam int LAST = WE_LO + WE_HI - 1;
    localparam int CNTW = $clog2(LAST + 2);

    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start && !busy) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == CNTW'(LAST)) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        low = busy && (cnt_q < CNTW'(WE_LO));
        fin = busy && (cnt_q == CNTW'(LAST));
    end

    // R6: a new pulse is only requested once the previous one has ended
    assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/nps_rotor.sv
module nps_rotor #(
    parameter int NUM_CHIPS = 4,
    parameter int ROW_W = 24
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         advance,
    output logic [$clog2(NUM_CHIPS)-1:0] chip,
    output logic [ROW_W-1:0]             page
);
    localparam int CW = $clog2(NUM_CHIPS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip <= '0;
            page <= '0;
        end else if (advance) begin
            if (chip == CW'(NUM_CHIPS - 1)) begin
                chip <= '0;
                page <= page + 1'b1;
            end else begin
                chip <= chip + 1'b1;
            end
        end
    end

    // R4: wrapping from the last device starts the next page address
    assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && chip == CW'(NUM_CHIPS - 1)) |=> (chip == '0 && page == $past(page) + 1'b1));
endmodule

// File: rtl/nand_page_sched.sv
module nand_page_sched
    import nps_pkg::*;
#(
    parameter int NUM_CHIPS  = 4,
    parameter int PAGE_BYTES = 16,
    parameter int ROW_BYTES  = 3,
    parameter int WE_LO      = 2,
    parameter int WE_HI      = 2,
    parameter int SETUP      = 2
)(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [7:0]                   in_data,
    output logic                         in_ready,
    input  logic [NUM_CHIPS-1:0]         chip_rdy,
    output logic [7:0]                   nand_io,
    output logic                         nand_ce_n,
    output logic                         nand_cle,
    output logic                         nand_ale,
    output logic [NUM_CHIPS-1:0]         nand_we_n,
    output logic [NUM_CHIPS-1:0]         nand_re_n,
    output logic                         done_pulse,
    output logic [$clog2(NUM_CHIPS)-1:0] done_chip,
    output logic [8*ROW_BYTES-1:0]       done_page
);
    localparam int CW      = $clog2(NUM_CHIPS);
    localparam int ROW_W   = 8 * ROW_BYTES;
    localparam int ADR_CYC = COL_BYTES + ROW_BYTES;
    localparam int AIW     = $clog2(ADR_CYC);
    localparam int BCW     = $clog2(PAGE_BYTES + 1);
    localparam int SUW     = $clog2(SETUP + 1);

    sched_state_e state_q, state_d;

    logic [SUW-1:0]   su_cnt;
    logic [BCW-1:0]   byte_cnt;
    logic [AIW-1:0]   adr_idx;
    logic             issued;
    logic [BUS_W-1:0] io_q;
    logic [BUS_W-1:0] bus_val;
    logic             stb_start, stb_busy, stb_low, stb_fin;
    logic [CW-1:0]    cur_chip;
    logic [ROW_W-1:0] page_q;
    logic             su_state, su_last, byte_full, adr_last;
    logic [8*ADR_CYC-1:0] adr_word;
    logic [BUS_W-1:0] adr_byte;

    nps_strobe #(.WE_LO(WE_LO), .WE_HI(WE_HI)) i_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .start (stb_start),
        .busy  (stb_busy),
        .low   (stb_low),
        .fin   (stb_fin)
    );

    nps_rotor #(.NUM_CHIPS(NUM_CHIPS), .ROW_W(ROW_W)) i_rotor (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (state_q == ST_DONE),
        .chip    (cur_chip),
        .page    (page_q)
    );

    assign su_state  = (state_q == ST_CMD_SU) || (state_q == ST_ADR_SU) ||
                       (state_q == ST_DAT_SU) || (state_q == ST_FIN_SU);
    assign su_last   = (su_cnt == SUW'(SETUP - 1));
    assign byte_full = (byte_cnt == BCW'(PAGE_BYTES));
    assign adr_last  = (adr_idx == AIW'(ADR_CYC - 1));
    assign adr_word  = {page_q, {(8*COL_BYTES){1'b0}}};
    assign adr_byte  = adr_word[int'(adr_idx)*8 +: 8];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:   if (chip_rdy[cur_chip])          state_d = ST_CMD_SU;
            ST_CMD_SU: if (su_last)                     state_d = ST_CMD;
            ST_CMD:    if (stb_fin)                     state_d = ST_ADR_SU;
            ST_ADR_SU: if (su_last)                     state_d = ST_ADR;
            ST_ADR:    if (stb_fin && adr_last)         state_d = ST_DAT_SU;
            ST_DAT_SU: if (su_last)                     state_d = ST_DAT;
            ST_DAT:    if (stb_fin && byte_full)        state_d = ST_FIN_SU;
            ST_FIN_SU: if (su_last)                     state_d = ST_FIN;
            ST_FIN:    if (stb_fin)                     state_d = ST_DONE;
            ST_DONE:                                    state_d = ST_WAIT;
            default:                                    state_d = ST_WAIT;
        endcase
    end

    // output and request decode
    always_comb begin
        nand_cle   = 1'b0;
        nand_ale   = 1'b0;
        nand_ce_n  = 1'b0;
        in_ready   = 1'b0;
        stb_start  = 1'b0;
        bus_val    = io_q;
        done_pulse = 1'b0;
        unique case (state_q)
            ST_WAIT:   nand_ce_n = 1'b1;
            ST_CMD_SU: nand_cle = 1'b1;
            ST_CMD: begin
                nand_cle  = 1'b1;
                bus_val   = OP_PROGRAM;
                stb_start = !stb_busy && !issued;
            end
            ST_ADR_SU: nand_ale = 1'b1;
            ST_ADR: begin
                nand_ale  = 1'b1;
                bus_val   = adr_byte;
                stb_start = !stb_busy && !issued;
            end
            ST_DAT_SU: ;
            ST_DAT: begin
                in_ready  = !stb_busy && !byte_full;
                bus_val   = in_data;
                stb_start = in_valid && !stb_busy && !byte_full;
            end
            ST_FIN_SU: nand_cle = 1'b1;
            ST_FIN: begin
                nand_cle  = 1'b1;
                bus_val   = OP_CONFIRM;
                stb_start = !stb_busy && !issued;
            end
            ST_DONE: begin
                nand_ce_n  = 1'b1;
                done_pulse = 1'b1;
            end
            default: nand_ce_n = 1'b1;
        endcase
    end

    // sequence counters and bus register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            su_cnt   <= '0;
            byte_cnt <= '0;
            adr_idx  <= '0;
            issued   <= 1'b0;
            io_q     <= '0;
        end else begin
            if (stb_start) io_q <= bus_val;
            if (stb_start)    issued <= 1'b1;
            else if (stb_fin) issued <= 1'b0;
            su_cnt <= su_state ? su_cnt + 1'b1 : '0;
            if (state_q == ST_WAIT) begin
                byte_cnt <= '0;
                adr_idx  <= '0;
            end else begin
                if (state_q == ST_DAT && stb_start)            byte_cnt <= byte_cnt + 1'b1;
                if (state_q == ST_ADR && stb_fin && !adr_last) adr_idx  <= adr_idx + 1'b1;
            end
        end
    end

    assign nand_io   = io_q;
    assign done_chip = cur_chip;
    assign done_page = page_q;

    for (genvar g = 0; g < NUM_CHIPS; g++) begin : g_chip
        assign nand_we_n[g] = !(stb_low && (cur_chip == CW'(g)));
        assign nand_re_n[g] = 1'b1;
    end

    assert_one_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~nand_we_n) <= 1);

    assert_no_cle_ale_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_ce_with_we_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_we_n != '1) |-> !nand_ce_n);

    assert_latch_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nand_cle) || $fell(nand_cle) || $rose(nand_ale) || $fell(nand_ale)) |-> (&nand_we_n));

    assert_io_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((nand_we_n != '1) && $past(nand_we_n != '1)) |-> $stable(nand_io));

    assert_wait_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !chip_rdy[cur_chip]) |=> ((&nand_we_n) && !in_ready));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_accept_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (nand_we_n != '1));
endmodule

// File: tb/test_nand_page_sched.sv
module test_nand_page_sched;
    localparam int NCH = 4;
    localparam int PB  = 8;
    localparam int RB  = 3;
    localparam int LO  = 2;
    localparam int HI  = 1;
    localparam int SU  = 2;
    localparam int PER_PAGE = 1 + 2 + RB + PB + 1;
    localparam int LOGN = 512;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic [7:0] in_data = 0;
    logic in_ready;
    logic [NCH-1:0] chip_rdy;
    logic [7:0] nand_io;
    logic nand_ce_n, nand_cle, nand_ale, done_pulse;
    logic [NCH-1:0] nand_we_n, nand_re_n;
    logic [1:0] done_chip;
    logic [8*RB-1:0] done_page;

    always #5 clk = ~clk;

    nand_page_sched #(.NUM_CHIPS(NCH), .PAGE_BYTES(PB), .ROW_BYTES(RB),
                      .WE_LO(LO), .WE_HI(HI), .SETUP(SU)) i_nand_page_sched (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .chip_rdy(chip_rdy), .nand_io(nand_io),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .done_pulse(done_pulse),
        .done_chip(done_chip), .done_page(done_page));

    int total = 0, bad = 0;
    int busy_time = 20;

    // device model and bus monitor
    int log_chip [LOGN];
    int log_kind [LOGN];
    int log_val  [LOGN];
    int log_n = 0;
    int dn_chip [64];
    int dn_page [64];
    int done_n = 0;
    int busy_cnt [NCH];
    int lo_run = 0, hi_run = 100, su_run = 100;
    int v_tim = 0, v_io = 0, v_su = 0, v_cla = 0, v_ce = 0, v_multi = 0, v_re = 0, v_busy = 0;
    logic [NCH-1:0] prev_we = '1;
    logic [7:0] prev_io = 0;
    logic prev_cle = 0, prev_ale = 0;

    initial begin
        chip_rdy = '1;
        for (int c = 0; c < NCH; c++) busy_cnt[c] = 0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (busy_cnt[c] > 0) begin
                    busy_cnt[c] = busy_cnt[c] - 1;
                    if (busy_cnt[c] == 0) chip_rdy[c] = 1'b1;
                end
            end
            if ($countones(~nand_we_n) > 1) v_multi++;
            if (nand_re_n != '1) v_re++;
            if (nand_cle && nand_ale) v_cla++;
            if (nand_cle != prev_cle || nand_ale != prev_ale) begin
                if (nand_we_n != '1) v_su++;
                su_run = 0;
            end else su_run++;
            if (nand_we_n != '1) begin
                if (nand_ce_n) v_ce++;
                if (prev_we == '1) begin
                    if (hi_run < HI) v_tim++;
                    if (su_run < SU) v_su++;
                    for (int c = 0; c < NCH; c++)
                        if (!nand_we_n[c] && !chip_rdy[c]) v_busy++;
                    lo_run = 0;
                end else if (nand_io != prev_io) v_io++;
                lo_run++;
            end else begin
                if (prev_we != '1) begin
                    if (lo_run != LO) v_tim++;
                    for (int c = 0; c < NCH; c++) begin
                        if (!prev_we[c] && log_n < LOGN) begin
                            log_chip[log_n] = c;
                            log_kind[log_n] = prev_cle ? 0 : (prev_ale ? 1 : 2);
                            log_val[log_n]  = int'(prev_io);
                            log_n++;
                            if (prev_cle && prev_io == 8'h10) begin
                                chip_rdy[c] = 1'b0;
                                busy_cnt[c] = busy_time;
                            end
                        end
                    end
                    hi_run = 0;
                end
                hi_run++;
            end
            if (done_pulse && done_n < 64) begin
                dn_chip[done_n] = int'(done_chip);
                dn_page[done_n] = int'(done_page);
                done_n++;
            end
            prev_we  = nand_we_n;
            prev_io  = nand_io;
            prev_cle = nand_cle;
            prev_ale = nand_ale;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int byte_of(input int j);
        return (j * 13 + 5) & 255;
    endfunction

    task automatic send_page(input int k, input int gap);
        for (int b = 0; b < PB; b++) begin
            in_data  = 8'(byte_of(k * PB + b));
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
    endtask

    task automatic wait_done(input int n);
        while (done_n < n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // compare the logged latch sequence of page k with the expected one
    task automatic check_page(input int k);
        int base, ch, pg, errs, at, act, exp, kexp, vexp;
        base = k * PER_PAGE; ch = k % NCH; pg = k / NCH; errs = 0; at = 0; act = 0; exp = 0;
        for (int i = 0; i < PER_PAGE; i++) begin
            if (i == 0)                  begin kexp = 0; vexp = 8'h80; end
            else if (i < 3)              begin kexp = 1; vexp = 0; end
            else if (i < 3 + RB)         begin kexp = 1; vexp = (pg >> (8 * (i - 3))) & 255; end
            else if (i < 3 + RB + PB)    begin kexp = 2; vexp = byte_of(k * PB + i - 3 - RB); end
            else                         begin kexp = 0; vexp = 8'h10; end
            if (base + i >= log_n) begin
                if (errs == 0) begin at = i; act = -1; exp = vexp; end
                errs++;
            end else if (log_chip[base+i] != ch || log_kind[base+i] != kexp || log_val[base+i] != vexp) begin
                if (errs == 0) begin at = i; act = log_val[base+i] + 1000 * log_chip[base+i]; exp = vexp + 1000 * ch; end
                errs++;
            end
        end
        chk(errs == 0, "R2/R3", $sformatf("page %0d latch item %0d (chip*1000+val)", k, at), act, exp);
        chk(k < done_n && dn_chip[k] == ch, "R9", $sformatf("done_chip page %0d", k), k < done_n ? dn_chip[k] : -1, ch);
        chk(k < done_n && dn_page[k] == pg, "R4", $sformatf("done_page page %0d", k), k < done_n ? dn_page[k] : -1, pg);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(in_ready == 0 && done_pulse == 0, "R1", "in_ready/done in reset", int'(in_ready) + 2 * int'(done_pulse), 0);
        chk(nand_we_n == '1 && nand_re_n == '1, "R1", "strobes in reset", int'(nand_we_n & nand_re_n), 15);
        chk(nand_ce_n == 1 && !nand_cle && !nand_ale, "R1", "ce/cle/ale in reset",
            int'(nand_ce_n) + 2 * int'(nand_cle) + 4 * int'(nand_ale), 1);
    endtask

    task automatic test_rotation();
        busy_time = 20;
        for (int k = 0; k < NCH; k++) send_page(k, 0);
        wait_done(NCH);
        for (int k = 0; k < NCH; k++) check_page(k);
    endtask

    task automatic test_gaps();
        for (int k = NCH; k < 2 * NCH; k++) send_page(k, 3);
        wait_done(2 * NCH);
        for (int k = NCH; k < 2 * NCH; k++) check_page(k);   // R10 with idle gaps
    endtask

    task automatic test_wait_busy();
        int rdy_seen;
        busy_time = 600;
        for (int k = 2 * NCH; k < 3 * NCH; k++) send_page(k, 0);
        wait_done(3 * NCH);
        chk(chip_rdy[0] == 0, "R5", "chip 0 still busy", int'(chip_rdy[0]), 0);
        rdy_seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (in_ready || nand_we_n != '1) rdy_seen++;
        end
        chk(rdy_seen == 0, "R5", "in_ready/strobe while waiting", rdy_seen, 0);
        send_page(3 * NCH, 0);
        wait_done(3 * NCH + 1);
        check_page(3 * NCH);
        chk(v_busy == 0, "R5", "strobes to busy device", v_busy, 0);
    endtask

    task automatic check_bus_rules();
        chk(v_tim == 0, "R6", "strobe low/high timing errors", v_tim, 0);
        chk(v_io == 0, "R6", "io change while strobe low", v_io, 0);
        chk(v_su == 0, "R7", "latch setup errors", v_su, 0);
        chk(v_cla == 0, "R8", "cle and ale together", v_cla, 0);
        chk(v_ce == 0, "R8", "strobe without chip enable", v_ce, 0);
        chk(v_multi == 0, "R3", "more than one strobe low", v_multi, 0);
        chk(v_re == 0, "R3", "read strobe low", v_re, 0);
        chk(done_n == 3 * NCH + 1, "R9", "done pulse count", done_n, 3 * NCH + 1);
        chk(log_n == (3 * NCH + 1) * PER_PAGE, "R2", "latched item count", log_n, (3 * NCH + 1) * PER_PAGE);
    endtask

    bit finished = 0;

    initial begin
        rst_n = 0;
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1;
        test_rotation();
        test_gaps();
        test_wait_busy();
        check_bus_rules();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule